// File: doc/BRIEF.md
# CAN Bit Destuffer

This block sits between a bit sampler and a CAN frame parser. The sampler hands it one raw bit at a time as a valid/value pair. The block follows the runs of identical raw bits. When a run reaches its limit, the raw bit that comes next is the inserted stuff bit. That bit is removed from the stream, and a one-cycle marker reports that it was removed. All other bits are forwarded with one cycle of latency. Each forwarded bit carries its raw position and its destuffed position within the frame.

A stuff bit stays in the run history, so it can start a new run. If the bit that arrives at a stuff position has the same value as the run, it is not a stuff bit. The block flags a stuff error for one cycle and forwards that bit as a frame bit. The parser drives a start-of-frame marker with the first bit of each frame, which clears the history and the indices. When the frame reaches its fixed-form tail, the parser raises a stuffing-off input. From then on, bits are forwarded without any stuff check.

The run history has two interchangeable variants, selected by a parameter: a saturating run-length counter, or a shift window of the last raw bits. Both variants behave the same at the ports.

Top module: `can_bit_destuffer`

## Requirements
- R1: While reset is held and after it is released, `dst_valid`, `dst_bit`, `dst_stuff` and `stuff_err` read 0. `dst_raw_idx` and `dst_bit_idx` read all ones, so the first bit after reset takes index 0.
- R2: A raw bit accepted with `raw_valid` high that is not a stuff bit appears on `dst_bit` with `dst_valid` high exactly one clock later.
- R3: Stuffing must be enabled (`stuff_off` low). When `RUN_LEN` (default 5) consecutive accepted raw bits of one value are followed by a bit of the other value, that bit is dropped: one clock later `dst_stuff` is 1 and `dst_valid` is 0.
- R4: A dropped stuff bit counts as the first bit of a new run. With the default limit, a stuff 1 followed by four more 1s makes the next 0 a stuff bit.
- R5: When stuffing is enabled and a bit at a stuff position equals the run value, `stuff_err` pulses for one cycle, one clock later, together with `dst_valid` and that bit. The run stays at its limit, so each further identical bit also raises `stuff_err`.
- R6: A bit accepted while `stuff_off` is high is always forwarded and never raises `dst_stuff` or `stuff_err`, whatever run precedes it.
- R7: A bit accepted with `frame_start` high clears the run history. It is forwarded as the first bit of a new run, with `dst_raw_idx` and `dst_bit_idx` both 0 one clock later. `frame_start` without `raw_valid` has no effect.
- R8: `dst_raw_idx` advances by one for every accepted raw bit, stuff bits included. `dst_bit_idx` advances only for forwarded bits. On a `dst_stuff` cycle, `dst_bit_idx` shows the index the next forwarded bit will take.
- R9: A cycle with `raw_valid` low leaves the run history unchanged. One clock later `dst_valid`, `dst_stuff` and `stuff_err` are 0, and `dst_bit` and both indices hold their values.
- R10: The counter variant (`HIST_KIND` = HIST_COUNT) and the window variant (`HIST_KIND` = HIST_WINDOW) give identical port behaviour for every input sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_valid | input | 1 | A sampled raw bit is present this cycle |
| raw_bit | input | 1 | Sampled raw bit value (1 = recessive) |
| frame_start | input | 1 | This raw bit is the first bit of a frame |
| stuff_off | input | 1 | Stuffing disabled for this raw bit (frame tail) |
| dst_valid | output | 1 | A destuffed frame bit is presented |
| dst_bit | output | 1 | Destuffed bit value |
| dst_stuff | output | 1 | The raw bit accepted one cycle earlier was a removed stuff bit |
| stuff_err | output | 1 | A bit at a stuff position matched the run value |
| dst_raw_idx | output | IDX_W | Raw position of the bit just handled |
| dst_bit_idx | output | IDX_W | Destuffed position of the bit just handled |

## Verification
Every result is due exactly one clock after the edge that accepts the raw bit: the data, stuff marker, error flag and both indices all pass through a single output register. The bench drives each raw bit just after a falling edge. Its reference model computes that bit's expected outputs before the rising edge, and the bench compares at the next falling edge, half a period after the outputs change. On idle cycles the same comparison checks that the pulses drop and that the bit and indices hold. Both history variants run side by side against the one model.

// File: rtl/can_destuff_pkg.sv
package can_destuff_pkg;

   // Implementation choice for the raw-bit run history.
   typedef enum logic [0:0] {
      HIST_COUNT  = 1'b0,
      HIST_WINDOW = 1'b1
   } hist_kind_e;

   // Classification of one accepted raw bit.
   typedef struct packed {
      logic fwd;    // forwarded as a frame bit
      logic drop;   // removed stuff bit
      logic err;    // stuff position violated
   } bit_class_t;

endpackage

// File: rtl/can_destuff_run.sv
module can_destuff_run
   import can_destuff_pkg::*;
#(
   parameter int         RUN_LEN = 5,
   parameter hist_kind_e KIND    = HIST_COUNT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,       // a raw bit is accepted
   input  logic clr,       // accepted bit opens a new frame
   input  logic bit_in,
   output logic full_run,  // the last RUN_LEN raw bits are identical
   output logic run_bit    // value of the most recent raw bit
);

   localparam int CW = $clog2(RUN_LEN + 1);
   localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);
   localparam logic [CW-1:0] ONE   = CW'(1);

   generate
      if (KIND == HIST_COUNT) begin : g_count
         logic [CW-1:0] len_q;
         logic          val_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               len_q <= '0;
               val_q <= 1'b1;
            end else if (adv) begin
               val_q <= bit_in;
               if (clr) begin
                  len_q <= ONE;
               end else if ((bit_in == val_q) && (len_q != '0)) begin
                  if (len_q != LIMIT) begin
                     len_q <= len_q + ONE;
                  end
               end else begin
                  len_q <= ONE;
               end
            end
         end

         assign full_run = (len_q == LIMIT);
         assign run_bit  = val_q;
      end else begin : g_window
         logic [RUN_LEN-1:0] win_q;
         logic [CW-1:0]      fill_q;
         logic               same_w;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win_q  <= '1;
               fill_q <= '0;
            end else if (adv) begin
               win_q <= {win_q[RUN_LEN-2:0], bit_in};
               if (clr) begin
                  fill_q <= ONE;
               end else if (fill_q != LIMIT) begin
                  fill_q <= fill_q + ONE;
               end
            end
         end

         assign same_w   = (win_q == '0) || (win_q == '1);
         assign full_run = (fill_q == LIMIT) && same_w;
         assign run_bit  = win_q[0];
      end
   endgenerate

endmodule

// File: rtl/can_destuff_index.sv
module can_destuff_index #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             clr,
   input  logic             drop,
   output logic [IDX_W-1:0] raw_idx,  // raw position of the current bit
   output logic [IDX_W-1:0] bit_idx   // destuffed position of the current bit
);

   localparam logic [IDX_W-1:0] STEP = IDX_W'(1);

   logic [IDX_W-1:0] raw_next_q;
   logic [IDX_W-1:0] bit_next_q;

   assign raw_idx = clr ? '0 : raw_next_q;
   assign bit_idx = clr ? '0 : bit_next_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_next_q <= '0;
         bit_next_q <= '0;
      end else if (adv) begin
         raw_next_q <= raw_idx + STEP;
         bit_next_q <= drop ? bit_idx : (bit_idx + STEP);
      end
   end

endmodule

// File: rtl/can_destuff_classify.sv
module can_destuff_classify
   import can_destuff_pkg::*;
(
   input  logic       adv,
   input  logic       clr,
   input  logic       off,
   input  logic       bit_in,
   input  logic       full_run,
   input  logic       run_bit,
   output bit_class_t cls
);

   logic at_pos;

   // A frame-opening bit never sits at a stuff position.
   assign at_pos   = adv && full_run && !clr && !off;
   assign cls.drop = at_pos && (bit_in != run_bit);
   assign cls.err  = at_pos && (bit_in == run_bit);
   assign cls.fwd  = adv && !cls.drop;

endmodule

// File: rtl/can_bit_destuffer.sv
module can_bit_destuffer
   import can_destuff_pkg::*;
#(
   parameter int         RUN_LEN   = 5,
   parameter int         IDX_W     = 8,
   parameter hist_kind_e HIST_KIND = HIST_COUNT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw_valid,
   input  logic             raw_bit,
   input  logic             frame_start,
   input  logic             stuff_off,
   output logic             dst_valid,
   output logic             dst_bit,
   output logic             dst_stuff,
   output logic             stuff_err,
   output logic [IDX_W-1:0] dst_raw_idx,
   output logic [IDX_W-1:0] dst_bit_idx
);

   generate
      if (RUN_LEN < 2) begin : g_bad_run
         $error("can_bit_destuffer: RUN_LEN must be at least 2");
      end
      if (IDX_W < 2) begin : g_bad_idx
         $error("can_bit_destuffer: IDX_W must be at least 2");
      end
   endgenerate

   logic             clr_w;
   logic             full_w;
   logic             last_w;
   bit_class_t       cls_w;
   logic [IDX_W-1:0] raw_idx_w;
   logic [IDX_W-1:0] bit_idx_w;

   assign clr_w = raw_valid && frame_start;

   can_destuff_run #(
      .RUN_LEN (RUN_LEN),
      .KIND    (HIST_KIND)
   ) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (raw_valid),
      .clr      (clr_w),
      .bit_in   (raw_bit),
      .full_run (full_w),
      .run_bit  (last_w)
   );

   can_destuff_classify u_cls (
      .adv      (raw_valid),
      .clr      (clr_w),
      .off      (stuff_off),
      .bit_in   (raw_bit),
      .full_run (full_w),
      .run_bit  (last_w),
      .cls      (cls_w)
   );

   can_destuff_index #(
      .IDX_W (IDX_W)
   ) u_idx (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (raw_valid),
      .clr     (clr_w),
      .drop    (cls_w.drop),
      .raw_idx (raw_idx_w),
      .bit_idx (bit_idx_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dst_valid   <= 1'b0;
         dst_bit     <= 1'b0;
         dst_stuff   <= 1'b0;
         stuff_err   <= 1'b0;
         dst_raw_idx <= '1;
         dst_bit_idx <= '1;
      end else begin
         dst_valid <= cls_w.fwd;
         dst_stuff <= cls_w.drop;
         stuff_err <= cls_w.err;
         if (raw_valid) begin
            dst_bit     <= raw_bit;
            dst_raw_idx <= raw_idx_w;
            dst_bit_idx <= bit_idx_w;
         end
      end
   end

endmodule

// File: rtl/can_destuff_chk.sv
module can_destuff_chk #(
   parameter int IDX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             raw_valid,
   input logic             raw_bit,
   input logic             frame_start,
   input logic             stuff_off,
   input logic             dst_valid,
   input logic             dst_bit,
   input logic             dst_stuff,
   input logic             stuff_err,
   input logic [IDX_W-1:0] dst_raw_idx,
   input logic [IDX_W-1:0] dst_bit_idx
);

   assert_fwd_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dst_valid |-> $past(raw_valid));

   assert_drop_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dst_valid, dst_stuff}));

   assert_err_passes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stuff_err |-> (dst_valid && !dst_stuff));

   assert_off_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_valid && stuff_off) |=> (dst_valid && !dst_stuff && !stuff_err));

   assert_sof_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_valid && frame_start) |=>
         (dst_raw_idx == '0 && dst_bit_idx == '0 && dst_valid && !stuff_err));

   assert_raw_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_valid && !frame_start) |=>
         (dst_raw_idx == $past(dst_raw_idx) + IDX_W'(1)));

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !raw_valid |=> (!dst_valid && !dst_stuff && !stuff_err &&
                      $stable(dst_raw_idx) && $stable(dst_bit_idx) && $stable(dst_bit)));

endmodule

bind can_bit_destuffer can_destuff_chk #(.IDX_W(IDX_W)) u_destuff_chk (.*);

// File: tb/can_bit_destuffer_test.sv
module can_bit_destuffer_test;
   import can_destuff_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int RUNL       = 5;
   localparam int IW         = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic raw_valid = 1'b0, raw_bit = 1'b0, frame_start = 1'b0, stuff_off = 1'b0;

   logic          a_valid, a_bit, a_stuff, a_err;
   logic [IW-1:0] a_raw, a_idx;
   logic          b_valid, b_bit, b_stuff, b_err;
   logic [IW-1:0] b_raw, b_idx;

   always #(CLK_PERIOD/2) clk = ~clk;

   can_bit_destuffer #(.RUN_LEN(RUNL), .IDX_W(IW), .HIST_KIND(HIST_COUNT)) uut (
      .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .raw_bit(raw_bit),
      .frame_start(frame_start), .stuff_off(stuff_off),
      .dst_valid(a_valid), .dst_bit(a_bit), .dst_stuff(a_stuff), .stuff_err(a_err),
      .dst_raw_idx(a_raw), .dst_bit_idx(a_idx));

   can_bit_destuffer #(.RUN_LEN(RUNL), .IDX_W(IW), .HIST_KIND(HIST_WINDOW)) uut_win (
      .clk(clk), .rst_n(rst_n), .raw_valid(raw_valid), .raw_bit(raw_bit),
      .frame_start(frame_start), .stuff_off(stuff_off),
      .dst_valid(b_valid), .dst_bit(b_bit), .dst_stuff(b_stuff), .stuff_err(b_err),
      .dst_raw_idx(b_raw), .dst_bit_idx(b_idx));

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // reference model state
   bit hist[$];
   int raw_next = 0, bit_next = 0;
   bit e_valid = 0, e_bit = 0, e_stuff = 0, e_err = 0;
   int e_raw = 255, e_idx = 255;

   task automatic model(input bit v, input bit b, input bit s, input bit off);
      bit at_pos;
      e_valid = 0; e_stuff = 0; e_err = 0;
      if (!v) return;
      if (s) begin hist.delete(); raw_next = 0; bit_next = 0; end
      at_pos = !off && !s && hist.size() >= RUNL;
      if (at_pos)
         for (int k = 1; k < RUNL; k++)
            if (hist[hist.size()-1-k] != hist[hist.size()-1]) at_pos = 0;
      e_stuff = at_pos && (b != hist[hist.size()-1]);
      e_err   = at_pos && (b == hist[hist.size()-1]);
      e_valid = !e_stuff;
      e_bit   = b;
      e_raw   = raw_next;
      e_idx   = bit_next;
      raw_next = (raw_next + 1) % 256;
      if (!e_stuff) bit_next = (bit_next + 1) % 256;
      hist.push_back(b);
      if (hist.size() > 16) void'(hist.pop_front());
   endtask

   task automatic cmp1(input string who, input string tag, input bit v, input bit bt,
                       input bit st, input bit er, input logic [IW-1:0] r, input logic [IW-1:0] ix);
      checks++;
      if (v !== e_valid || (e_valid && bt !== e_bit) || st !== e_stuff || er !== e_err) begin
         errors++;
         $display("FAIL %s %s: valid/bit/stuff/err=%b%b%b%b expected %b%b%b%b",
                  tag, who, v, bt, st, er, e_valid, e_bit, e_stuff, e_err);
      end
      checks++;
      if (int'(r) != e_raw || int'(ix) != e_idx) begin
         errors++;
         $display("FAIL R8 %s (%s): raw_idx=%0d bit_idx=%0d expected %0d %0d",
                  who, tag, r, ix, e_raw, e_idx);
      end
   endtask

   // drive one raw cycle just after a falling edge; compare at the next falling edge
   task automatic step(input bit v, input bit b, input bit s, input bit off, input string tag);
      raw_valid = v; raw_bit = b; frame_start = s; stuff_off = off;
      model(v, b, s, off);
      @(negedge clk);
      cmp1("count", tag, a_valid, a_bit, a_stuff, a_err, a_raw, a_idx);
      cmp1("window R10", tag, b_valid, b_bit, b_stuff, b_err, b_raw, b_idx);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      bit prev;
      repeat (3) @(negedge clk);
      // R1 during reset
      checks++;
      if (a_valid || a_stuff || a_err || a_bit || a_raw !== '1 || a_idx !== '1 ||
          b_valid || b_stuff || b_err || b_bit || b_raw !== '1 || b_idx !== '1) begin
         errors++;
         $display("FAIL R1: outputs %b%b%b%b raw=%0d idx=%0d expected 0000 255 255",
                  a_valid, a_bit, a_stuff, a_err, a_raw, a_idx);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (a_valid || a_stuff || a_err || a_raw !== '1 || a_idx !== '1) begin
         errors++;
         $display("FAIL R1: after release valid/stuff/err=%b%b%b raw=%0d expected 000 255",
                  a_valid, a_stuff, a_err, a_raw);
      end
      // R1: first bit without frame_start takes index 0
      step(1, 1, 0, 0, "R1");

      // R3/R4: dominant run, stuff 1, run continues through the stuff bit
      step(1, 0, 1, 0, "R7");
      for (int i = 0; i < 4; i++) step(1, 0, 0, 0, "R2");
      step(1, 1, 0, 0, "R3");
      for (int i = 0; i < 4; i++) step(1, 1, 0, 0, "R4");
      step(1, 0, 0, 0, "R4");
      step(1, 1, 0, 0, "R2");

      // R5: sixth identical bit, then a seventh
      step(1, 0, 1, 0, "R7");
      for (int i = 0; i < 4; i++) step(1, 0, 0, 0, "R2");
      step(1, 0, 0, 0, "R5");
      step(1, 0, 0, 0, "R5");
      step(1, 1, 0, 0, "R5");

      // R9: idle gaps inside a run
      step(1, 1, 1, 0, "R7");
      step(1, 1, 0, 0, "R2");
      step(1, 1, 0, 0, "R2");
      for (int i = 0; i < 3; i++) step(0, 0, 1, 1, "R9");
      step(1, 1, 0, 0, "R9");
      step(1, 1, 0, 0, "R9");
      step(1, 0, 0, 0, "R9");

      // R6: stuffing off in the frame tail
      step(1, 1, 1, 0, "R7");
      for (int i = 0; i < 4; i++) step(1, 1, 0, 0, "R2");
      step(1, 1, 0, 1, "R6");
      step(1, 0, 0, 1, "R6");
      for (int i = 0; i < 5; i++) step(1, 0, 0, 1, "R6");
      step(1, 1, 0, 1, "R6");

      // R7: frame start in the middle of a run clears it
      step(1, 0, 1, 0, "R7");
      for (int i = 0; i < 3; i++) step(1, 1, 0, 0, "R2");
      step(1, 1, 1, 0, "R7");
      for (int i = 0; i < 4; i++) step(1, 1, 0, 0, "R7");
      step(1, 0, 0, 0, "R7");

      // R10 / R2: long pseudo-random traffic with long runs
      prev = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         bit v, b, s, off;
         v   = ($urandom % 8) != 0;
         b   = (($urandom % 5) == 0) ? ~prev : prev;
         s   = v && (($urandom % 90) == 0);
         off = (i % 120) > 100;
         if (v) prev = b;
         step(v, b, s, off, "R2");
      end
      step(0, 0, 0, 0, "R9");
      finish_run();
   end

endmodule